// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block turns one command request into the latch cycles that a NAND device with 512-byte pages expects on its control lines and I/O bus. A request carries an opcode, an optional column address and an optional page (row) address. Each part has its own valid flag, so "no column" and "no page" are explicit. The sequencer drives chip enable, the command and address latch enables, the write strobe and the I/O byte. It sends the cycles in order: command first, then one column cycle, then the row bytes. When the opcode is the data-input (program-load) command, it first sends a pointer command that selects the first half, the second half or the spare area of the page, and it rebases the column to that region.

After the last latch cycle, chip enable is released and the block decides how the command ends. Commands that have their own completion handling end at once. Other commands either wait on the device ready/busy pin, after a short guard interval, or wait for a fixed delay when the system has no ready pin. Write strobe timing comes from a small cycle counter: the strobe is low for `WE_LO` clocks and high for `WE_HI` clocks in every latch cycle. Data transfer is not part of this block.

Requests arrive over a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold the request fields stable until then. After acceptance the fields may change freely. Configuration pins (`cfg_*`) are sampled at acceptance.

Top module: `nsq_top`

## Requirements
- R1: After reset the block is idle: `nand_ce_n`=1, `nand_we_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_io`=0, `seq_done`=0, `req_ready`=1.
- R2: Each latch cycle lasts `WE_LO`+`WE_HI` clocks. `nand_we_n` is low for the first `WE_LO` clocks and high for the rest. CLE, ALE and the I/O value stay constant across the whole cycle. Exactly one of CLE and ALE is high in each cycle, and `nand_ce_n` stays low across all latch cycles of one request.
- R3: The cycle order is: optional pointer command, the opcode (CLE), one column cycle (ALE) if the column is valid, then, if the page is valid, page bits 7:0 and then bits 15:8, plus bits 23:16 when `cfg_row3`=1. The first latch cycle begins on the clock after acceptance.
- R4: For opcode 0x80 a pointer command comes first. If the column is valid and ≥ 512, the pointer is 0x50 and 512 is subtracted from the column. If the column is valid and ≥ 256 (but below 512), the pointer is 0x01 and 256 is subtracted. Otherwise the pointer is 0x00 and the column is unchanged.
- R5: With `cfg_bus16`=1 the column sent (after any rebase) is halved, except for the byte-wide opcodes 0x90, 0xEC, 0xEE and 0xEF. `nand_io[15:8]` is always 0.
- R6: Opcodes 0x10, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF end without a wait. The clock after the last latch cycle shows `seq_done`=1 with `nand_ce_n`=1, and the block is idle on the clock after that.
- R7: Opcode 0x00 with neither a column nor a page ends without a wait, as in R6.
- R8: Any other request with `cfg_has_rdy`=1 first holds `nand_ce_n` high for `TWB_CYC` clocks, ignoring `nand_rb`. It then stays until a clock edge where `nand_rb`=1 (ready). The next clock shows `seq_done`=1.
- R9: Any other request with `cfg_has_rdy`=0 waits exactly `DELAY_CYC` clocks after the last latch cycle and then shows `seq_done`=1, whatever the value of `nand_rb`.
- R10: `req_ready` is high only while idle. A request held valid while the block is busy is taken on the first edge after the block becomes idle. Changes to the request fields after acceptance have no effect on the cycles being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_cmd | input | 8 | Opcode |
| req_col | input | COL_W | Column address |
| req_col_vld | input | 1 | Column address present |
| req_page | input | ROW_W | Page (row) address |
| req_page_vld | input | 1 | Page address present |
| cfg_bus16 | input | 1 | Device uses a 16-bit data bus |
| cfg_row3 | input | 1 | Send three row address cycles |
| cfg_has_rdy | input | 1 | Ready/busy pin is wired |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 16 | I/O bus value |
| seq_done | output | 1 | One-clock pulse when a request ends |

## Verification
The bench targets the three pointer regions of the data-input command, including the columns at exactly 256 and 512. A wrong boundary or a missing rebase would send the wrong pointer opcode or an unshifted column byte. On a 16-bit bus it mixes halved and byte-wide opcodes, and it checks the order of halving relative to the rebase. It also toggles the ready pin early, late and not at all: a sequencer that skipped the guard interval would finish too soon, and one that ignored the delay mode would hang or finish early. Back-to-back requests with valid held high show whether a second request could slip in while busy, or whether scrambled fields after acceptance could leak into the cycles being sent.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

  localparam logic [7:0] OP_READ0   = 8'h00;
  localparam logic [7:0] OP_READ1   = 8'h01;
  localparam logic [7:0] OP_SPARE   = 8'h50;
  localparam logic [7:0] OP_DATAIN  = 8'h80;
  localparam logic [7:0] OP_PROG    = 8'h10;
  localparam logic [7:0] OP_ERASE_A = 8'h60;
  localparam logic [7:0] OP_ERASE_B = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_PARAM   = 8'hEC;
  localparam logic [7:0] OP_GETFEAT = 8'hEE;
  localparam logic [7:0] OP_SETFEAT = 8'hEF;

  // one bus latch cycle
  typedef struct packed {
    logic       cle;
    logic       ale;
    logic [7:0] dat;
  } latch_t;

  // how a request finishes after its latch cycles
  typedef enum logic [1:0] {
    FIN_NOW = 2'd0,
    FIN_RDY = 2'd1,
    FIN_DLY = 2'd2
  } fin_t;

  function automatic logic byte_wide_op(input logic [7:0] op);
    return (op == OP_IDENT) || (op == OP_PARAM) ||
           (op == OP_GETFEAT) || (op == OP_SETFEAT);
  endfunction

  function automatic logic skip_wait_op(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE_A) || (op == OP_ERASE_B) ||
           (op == OP_DATAIN) || (op == OP_STATUS) || (op == OP_IDENT) ||
           (op == OP_SETFEAT);
  endfunction

  function automatic latch_t mk_latch(input logic is_cmd, input logic [7:0] d);
    latch_t l;
    l.cle = is_cmd;
    l.ale = ~is_cmd;
    l.dat = d;
    return l;
  endfunction

endpackage

// File: rtl/nsq_plan.sv
module nsq_plan
  import nsq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int ROW_W      = 24,
  parameter int PAGE_BYTES = 512,
  parameter int SLOTS      = 6,
  localparam int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic [7:0]             cmd,
  input  logic [COL_W-1:0]       col,
  input  logic                   col_vld,
  input  logic [ROW_W-1:0]       page,
  input  logic                   page_vld,
  input  logic                   bus16,
  input  logic                   row3,
  input  logic                   has_rdy,
  output latch_t [SLOTS-1:0]     plan,
  output logic [CNT_W-1:0]       count,
  output fin_t                   fin
);

  localparam logic [COL_W-1:0] PG_SIZE = COL_W'(PAGE_BYTES);
  localparam logic [COL_W-1:0] PG_HALF = COL_W'(PAGE_BYTES / 2);

  logic [7:0]       ptr_op;
  logic [COL_W-1:0] col_reb;
  logic [COL_W-1:0] col_src;
  logic [COL_W-1:0] col_out;
  logic [23:0]      row24;

  assign row24 = 24'(page);

  // region pointer for the data-input command
  always_comb begin
    ptr_op  = OP_READ0;
    col_reb = col;
    if (col_vld && (col >= PG_SIZE)) begin
      ptr_op  = OP_SPARE;
      col_reb = col - PG_SIZE;
    end else if (col_vld && (col >= PG_HALF)) begin
      ptr_op  = OP_READ1;
      col_reb = col - PG_HALF;
    end
  end

  assign col_src = (cmd == OP_DATAIN) ? col_reb : col;
  assign col_out = (bus16 && !byte_wide_op(cmd)) ? (col_src >> 1) : col_src;

  // cycle list
  always_comb begin
    plan  = '0;
    count = '0;
    if (cmd == OP_DATAIN) begin
      plan[count] = mk_latch(1'b1, ptr_op);
      count       = count + 1'b1;
    end
    plan[count] = mk_latch(1'b1, cmd);
    count       = count + 1'b1;
    if (col_vld) begin
      plan[count] = mk_latch(1'b0, col_out[7:0]);
      count       = count + 1'b1;
    end
    if (page_vld) begin
      plan[count] = mk_latch(1'b0, row24[7:0]);
      count       = count + 1'b1;
      plan[count] = mk_latch(1'b0, row24[15:8]);
      count       = count + 1'b1;
      if (row3) begin
        plan[count] = mk_latch(1'b0, row24[23:16]);
        count       = count + 1'b1;
      end
    end
  end

  // ending decision
  always_comb begin
    if (skip_wait_op(cmd) || ((cmd == OP_READ0) && !col_vld && !page_vld))
      fin = FIN_NOW;
    else if (has_rdy)
      fin = FIN_RDY;
    else
      fin = FIN_DLY;
  end

endmodule

// File: rtl/nsq_strobe.sv
module nsq_strobe #(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2,
  localparam int W     = $clog2(LO_CYC + HI_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic we_n,
  output logic slot_end
);

  localparam logic [W-1:0] LAST = W'(LO_CYC + HI_CYC - 1);
  localparam logic [W-1:0] LOW  = W'(LO_CYC);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run)             cnt <= '0;
    else if (cnt == LAST)      cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign slot_end = run && (cnt == LAST);
  assign we_n     = !(run && (cnt < LOW));

endmodule

// File: rtl/nsq_timer.sv
module nsq_timer #(
  parameter int MAX_LEN = 2000,
  localparam int W      = $clog2(MAX_LEN + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= len - 1'b1;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/nsq_top.sv
module nsq_top
  import nsq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int ROW_W      = 24,
  parameter int PAGE_BYTES = 512,
  parameter int SLOTS      = 6,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int TWB_CYC    = 10,
  parameter int DELAY_CYC  = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_col_vld,
  input  logic [ROW_W-1:0] req_page,
  input  logic             req_page_vld,
  input  logic             cfg_bus16,
  input  logic             cfg_row3,
  input  logic             cfg_has_rdy,
  input  logic             nand_rb,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic [15:0]      nand_io,
  output logic             seq_done
);

  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int TMAX  = (TWB_CYC > DELAY_CYC) ? TWB_CYC : DELAY_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUS, ST_TWB, ST_RDYW, ST_DLY, ST_DONE
  } state_t;

  state_t             state;
  latch_t [SLOTS-1:0] lst_q;
  logic [CNT_W-1:0]   n_q, idx_q;
  fin_t               fin_q;

  latch_t [SLOTS-1:0] plan_w;
  logic [CNT_W-1:0]   count_w;
  fin_t               fin_w;
  logic               slot_end, tmr_exp, tmr_load;
  logic [TW-1:0]      tmr_len;
  latch_t             cur;
  logic               in_bus, last_slot;

  nsq_plan #(
    .COL_W(COL_W), .ROW_W(ROW_W), .PAGE_BYTES(PAGE_BYTES), .SLOTS(SLOTS)
  ) u_plan (
    .cmd(req_cmd), .col(req_col), .col_vld(req_col_vld),
    .page(req_page), .page_vld(req_page_vld),
    .bus16(cfg_bus16), .row3(cfg_row3), .has_rdy(cfg_has_rdy),
    .plan(plan_w), .count(count_w), .fin(fin_w)
  );

  assign in_bus = (state == ST_BUS);

  nsq_strobe #(.LO_CYC(WE_LO), .HI_CYC(WE_HI)) u_strobe (
    .clk(clk), .rst_n(rst_n), .run(in_bus),
    .we_n(nand_we_n), .slot_end(slot_end)
  );

  assign last_slot = (idx_q == n_q - 1'b1);
  assign tmr_load  = in_bus && slot_end && last_slot && (fin_q != FIN_NOW);
  assign tmr_len   = (fin_q == FIN_RDY) ? TW'(TWB_CYC) : TW'(DELAY_CYC);

  nsq_timer #(.MAX_LEN(TMAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      lst_q <= '0;
      n_q   <= '0;
      idx_q <= '0;
      fin_q <= FIN_NOW;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          lst_q <= plan_w;
          n_q   <= count_w;
          fin_q <= fin_w;
          idx_q <= '0;
          state <= ST_BUS;
        end
        ST_BUS: if (slot_end) begin
          if (last_slot) begin
            case (fin_q)
              FIN_RDY: state <= ST_TWB;
              FIN_DLY: state <= ST_DLY;
              default: state <= ST_DONE;
            endcase
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_TWB:  if (tmr_exp) state <= ST_RDYW;
        ST_RDYW: if (nand_rb) state <= ST_DONE;
        ST_DLY:  if (tmr_exp) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cur       = lst_q[idx_q];
  assign req_ready = (state == ST_IDLE);
  assign seq_done  = (state == ST_DONE);
  assign nand_ce_n = !in_bus;
  assign nand_cle  = in_bus && cur.cle;
  assign nand_ale  = in_bus && cur.ale;
  assign nand_io   = in_bus ? {8'h00, cur.dat} : 16'h0000;

endmodule

// File: rtl/nsq_chk.sv
module nsq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        nand_ce_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_we_n,
  input logic [15:0] nand_io,
  input logic        seq_done
);

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_strobe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_io) && $stable(nand_cle) && $stable(nand_ale)));

  assert_ce_has_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n |-> (nand_cle || nand_ale));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> (nand_io[15:8] == 8'h00));

  assert_done_ce_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> nand_ce_n);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (!seq_done && req_ready));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_we_n));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !nand_ce_n));

endmodule

bind nsq_top nsq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_io(nand_io), .seq_done(seq_done)
);

// File: tb/tb_nsq_top.sv
module tb_nsq_top;

  localparam int CLK_PERIOD = 10;
  localparam int LO  = 2;
  localparam int HI  = 3;
  localparam int TWB = 3;
  localparam int DLY = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cmd = 8'h00;
  logic [9:0]  req_col = '0;
  logic        req_col_vld = 1'b0;
  logic [23:0] req_page = '0;
  logic        req_page_vld = 1'b0;
  logic        cfg_bus16 = 1'b0;
  logic        cfg_row3 = 1'b0;
  logic        cfg_has_rdy = 1'b1;
  logic        nand_rb = 1'b1;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, seq_done;
  logic [15:0] nand_io;

  always #(CLK_PERIOD/2) clk = ~clk;

  nsq_top #(.WE_LO(LO), .WE_HI(HI), .TWB_CYC(TWB), .DELAY_CYC(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_col(req_col), .req_col_vld(req_col_vld),
    .req_page(req_page), .req_page_vld(req_page_vld),
    .cfg_bus16(cfg_bus16), .cfg_row3(cfg_row3), .cfg_has_rdy(cfg_has_rdy),
    .nand_rb(nand_rb), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_io(nand_io),
    .seq_done(seq_done)
  );

  typedef struct packed {
    logic        ce_n;
    logic        cle;
    logic        ale;
    logic        we_n;
    logic [15:0] io;
    logic        done;
    logic        rdy;
    logic        hold_rb;
    logic [7:0]  tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cur_tag = 2;
  bit   model_on = 1'b0;

  function automatic exp_t mk(input logic ce_n, input logic cle, input logic ale,
                              input logic we_n, input logic [15:0] io,
                              input logic done, input logic rdy,
                              input logic hold_rb, input int tag);
    exp_t e;
    e.ce_n = ce_n; e.cle = cle; e.ale = ale; e.we_n = we_n; e.io = io;
    e.done = done; e.rdy = rdy; e.hold_rb = hold_rb; e.tag = tag[7:0];
    return e;
  endfunction

  // behavioural reference: expected outputs, one entry per clock
  task automatic model_build();
    logic [7:0] bq[$];
    bit         cq[$];
    int         c;
    logic [7:0] op;
    int         tg;
    op = req_cmd;
    c  = int'(req_col);
    if (op == 8'h80) begin                       // R4 pointer and rebase
      if (req_col_vld && c >= 512)      begin bq.push_back(8'h50); c = c - 512; end
      else if (req_col_vld && c >= 256) begin bq.push_back(8'h01); c = c - 256; end
      else                                    bq.push_back(8'h00);
      cq.push_back(1'b1);
    end
    bq.push_back(op); cq.push_back(1'b1);        // R3 order
    if (req_col_vld) begin
      if (cfg_bus16 && !(op inside {8'h90, 8'hEC, 8'hEE, 8'hEF})) c = c / 2;  // R5
      bq.push_back(c[7:0]); cq.push_back(1'b0);
    end
    if (req_page_vld) begin
      bq.push_back(req_page[7:0]);  cq.push_back(1'b0);
      bq.push_back(req_page[15:8]); cq.push_back(1'b0);
      if (cfg_row3) begin bq.push_back(req_page[23:16]); cq.push_back(1'b0); end
    end
    foreach (bq[i])
      for (int k = 0; k < LO + HI; k++)
        exp_q.push_back(mk(1'b0, cq[i], !cq[i], (k >= LO), {8'h00, bq[i]},
                           1'b0, 1'b0, 1'b0, cur_tag));
    if ((op inside {8'h10, 8'h60, 8'hD0, 8'h80, 8'h70, 8'h90, 8'hEF}) ||
        (op == 8'h00 && !req_col_vld && !req_page_vld)) begin
      tg = (op == 8'h00) ? 7 : 6;                // R6 / R7
      exp_q.push_back(mk(1, 0, 0, 1, 16'h0, 1, 0, 0, tg));
    end else if (cfg_has_rdy) begin              // R8
      for (int k = 0; k < TWB; k++) exp_q.push_back(mk(1, 0, 0, 1, 16'h0, 0, 0, 0, 8));
      exp_q.push_back(mk(1, 0, 0, 1, 16'h0, 0, 0, 1, 8));
      exp_q.push_back(mk(1, 0, 0, 1, 16'h0, 1, 0, 0, 8));
    end else begin                               // R9
      for (int k = 0; k < DLY; k++) exp_q.push_back(mk(1, 0, 0, 1, 16'h0, 0, 0, 0, 9));
      exp_q.push_back(mk(1, 0, 0, 1, 16'h0, 1, 0, 0, 9));
    end
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      if (exp_q.size() == 0) begin
        if (req_valid) model_build();            // R10 accept only when idle
      end else if (exp_q[0].hold_rb) begin
        if (nand_rb) void'(exp_q.pop_front());
      end else begin
        void'(exp_q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    exp_t e;
    if (model_on) begin
      e = (exp_q.size() == 0) ? mk(1, 0, 0, 1, 16'h0, 0, 1, 0, 10) : exp_q[0];
      n_cmp++;
      if ({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_io, seq_done, req_ready} !==
          {e.ce_n, e.cle, e.ale, e.we_n, e.io, e.done, e.rdy}) begin
        n_bad++;
        $display("FAIL R%0d t=%0t actual ce_n=%b cle=%b ale=%b we_n=%b io=%h done=%b ready=%b expected ce_n=%b cle=%b ale=%b we_n=%b io=%h done=%b ready=%b",
                 e.tag, $time, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_io, seq_done, req_ready,
                 e.ce_n, e.cle, e.ale, e.we_n, e.io, e.done, e.rdy);
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  // rb_after: negedges after acceptance at which ready rises (<0: untouched)
  task automatic send(input logic [7:0] cmd, input int col, input bit cv,
                      input int pg, input bit pv, input int rb_after,
                      input int tag, input bit wait_idle);
    cur_tag      = tag;
    req_cmd      = cmd;
    req_col      = col[9:0];
    req_col_vld  = cv;
    req_page     = pg[23:0];
    req_page_vld = pv;
    req_valid    = 1'b1;
    if (rb_after >= 0) nand_rb = 1'b0;
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (wait_idle) begin
      // R10: scrambled fields after acceptance must not matter
      req_cmd = cmd ^ 8'hA5; req_col = ~req_col; req_page = ~req_page;
      req_col_vld = ~cv; req_page_vld = ~pv;
      for (int k = 1; !req_ready; k++) begin
        if (k == rb_after) nand_rb = 1'b1;
        @(negedge clk);
      end
      if (rb_after >= 0) nand_rb = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    n_cmp++;
    if ({nand_ce_n, nand_we_n, nand_cle, nand_ale, nand_io, seq_done, req_ready} !==
        {1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1}) begin
      n_bad++;
      $display("FAIL R1 actual ce_n=%b we_n=%b cle=%b ale=%b io=%h done=%b ready=%b expected 1 1 0 0 0000 0 1",
               nand_ce_n, nand_we_n, nand_cle, nand_ale, nand_io, seq_done, req_ready);
    end
    model_on = 1'b1;
    @(negedge clk);

    // R2 R3 R8: read with column and page, ready rises late
    send(8'h00, 5, 1, 24'h012345, 1, 40, 3, 1);
    // R3: three row cycles
    cfg_row3 = 1'b1;
    send(8'h00, 7, 1, 24'hABCDEF, 1, 2, 3, 1);          // R8: rb high before guard ends
    send(8'h60, 0, 0, 24'h0F1E2D, 1, -1, 3, 1);         // R6 erase setup
    cfg_row3 = 1'b0;
    // R4: three pointer regions and both boundaries
    send(8'h80, 3,   1, 24'h000100, 1, -1, 4, 1);
    send(8'h80, 255, 1, 24'h000101, 1, -1, 4, 1);
    send(8'h80, 256, 1, 24'h000102, 1, -1, 4, 1);
    send(8'h80, 300, 1, 24'h000103, 1, -1, 4, 1);
    send(8'h80, 511, 1, 24'h000104, 1, -1, 4, 1);
    send(8'h80, 512, 1, 24'h000105, 1, -1, 4, 1);
    send(8'h80, 520, 1, 24'h000106, 1, -1, 4, 1);
    send(8'h80, 0,   0, 24'h000107, 1, -1, 4, 1);
    // R5: 16-bit bus
    cfg_bus16 = 1'b1;
    send(8'h80, 300, 1, 24'h000200, 1, -1, 5, 1);
    send(8'h00, 499, 1, 24'h000201, 1, 30, 5, 1);
    send(8'h90, 8'h21, 1, 0, 0, -1, 5, 1);
    send(8'hEF, 8'h03, 1, 0, 0, -1, 5, 1);
    cfg_bus16 = 1'b0;
    // R6: commands with no wait
    send(8'h10, 0, 0, 0, 0, -1, 6, 1);
    send(8'hD0, 0, 0, 0, 0, -1, 6, 1);
    send(8'h70, 0, 0, 0, 0, -1, 6, 1);
    // R7: read with no addresses
    send(8'h00, 0, 0, 0, 0, -1, 7, 1);
    // R8: ready already high
    send(8'hFF, 0, 0, 0, 0, -1, 8, 1);
    // R9: no ready pin, rb held low throughout
    cfg_has_rdy = 1'b0;
    nand_rb = 1'b0;
    send(8'h01, 10, 1, 24'h000007, 1, -1, 9, 1);
    nand_rb = 1'b1;
    send(8'h00, 20, 1, 24'h000008, 1, -1, 9, 1);
    cfg_has_rdy = 1'b1;
    // R10: second request held valid while busy
    send(8'h60, 0, 0, 24'h000333, 1, -1, 10, 0);
    send(8'h00, 9, 1, 24'h000444, 1, 25, 10, 1);
    repeat (5) @(negedge clk);
    report();
  end

endmodule